// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Interrupt Detection

This block is a general-purpose I/O port of sixteen pins behind a small 16-bit register bus slave. The slave has a word address, a write strobe, write data and registered read data. Software picks the direction of each pin one at a time. It changes output pins atomically by writing ones to a set register or a clear register, so it never needs a read-modify-write sequence. It reads the pin levels after they pass a two-flop synchronizer.

Each pin can also raise an interrupt. A per-pin select picks level sensing or edge sensing. In level mode a polarity bit chooses the active level. In edge mode, separate rising and falling enables pick either edge or both. An event reaches the pending status only when the pin is unmasked and enabled. Edge events stay latched until software writes a one to the clear register. Level events are recomputed every cycle. All visible pending bits are ORed into one registered interrupt line.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, direction reads 0x0000, output value reads 0x0000, mask reads 0xFFFF, enable reads 0x0000, pending status reads 0x0000, and `irq` and `pin_oe`/`pin_out` are all 0.
- R2: Writing word address 0x4 (direction) drives `pin_oe`; a bit of 1 makes that pin an output and a bit of 0 an input.
- R3: Writing address 0x1 loads the output value, which drives `pin_out` and reads back from 0x1. Writing 1s to address 0x2 (set) forces those bits high. Writing 1s to address 0x3 (clear) forces those bits low. Bits written as 0 to 0x2 or 0x3 keep their value.
- R4: Address 0x0 returns the pin levels after a two-flop synchronizer, so a change on `pin_in` is readable no more than three clock edges later.
- R5: With the level-select bit set (address 0x5), a pin is pending while its synchronized level equals its polarity bit (address 0x6, 1 = high). Writing the clear register does not remove it while the level stays active, and it drops once the level goes inactive.
- R6: With the level-select bit at 0, the rising enable (address 0x7) latches a pending bit on a 0-to-1 change and the falling enable (address 0x8) latches one on a 1-to-0 change; each works independently, and with both set either edge latches.
- R7: An event becomes pending only when the mask bit (address 0x9) is 0 and the enable bit (address 0xA) is 1. Otherwise the pending status (address 0xB) keeps that bit at 0 and `irq` stays low.
- R8: Writing 1s to address 0xC clears the matching latched edge bits; bits written as 0 stay pending.
- R9: `irq` is a registered OR of all pending status bits: it is high when any bit reads as pending and low when none does.
- R10: Reads of the write-only addresses 0x2, 0x3 and 0xC return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the address |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output levels |
| pin_oe | output | 16 | Output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong latch or gate state shows up at the ports as an interrupt line that stays high after a clear, or as one that never rises. Pending status reads make that visible no more than four cycles after a pin change. A stuck output-value bit shows on `pin_out` on the cycle after the set or clear write that should have moved it. A broken synchronizer shows as a data-in read that is still stale three edges after a pin change. Level and edge pins are exercised side by side, so state that leaks between the two modes appears as extra pending bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIN   = 4'h0,
    A_OUT   = 4'h1,
    A_SET   = 4'h2,
    A_CLR   = 4'h3,
    A_DIR   = 4'h4,
    A_LSEL  = 4'h5,
    A_LPOL  = 4'h6,
    A_RISE  = 4'h7,
    A_FALL  = 4'h8,
    A_MASK  = 4'h9,
    A_EN    = 4'hA,
    A_PEND  = 4'hB,
    A_ICLR  = 4'hC
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] stg [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= raw;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign cur  = stg[STAGES-1];
  assign prev = stg[STAGES];

  // R4
  cur_follows_chk: assert property (@(posedge clk) disable iff (rst)
    prev == $past(cur));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] lvl_sel,
  input  logic [N-1:0] lvl_pol,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] gate;
  logic [N-1:0] pend_q;
  logic [N-1:0] edge_hit;

  assign gate = ~mask & en;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall, active;
    assign rise        = cur[i] & ~prev[i];
    assign fall        = ~cur[i] & prev[i];
    assign active      = ~(cur[i] ^ lvl_pol[i]);
    assign edge_hit[i] = ((rise & rise_en[i]) | (fall & fall_en[i])) & gate[i];

    always_ff @(posedge clk) begin
      if (rst)
        pend_q[i] <= 1'b0;
      else if (lvl_sel[i])
        pend_q[i] <= active & gate[i];
      else
        pend_q[i] <= (pend_q[i] & ~clr[i]) | edge_hit[i];
    end

    // R7
    gated_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[i]) |-> $past(gate[i]));

    // R8
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(clr[i]) && !$past(lvl_sel[i]) && !$past(edge_hit[i])) |-> !pend_q[i]);
  end

  assign status = pend_q & gate;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      din,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      lsel_q,
  output logic [N-1:0]      lpol_q,
  output logic [N-1:0]      rise_q,
  output logic [N-1:0]      fall_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      iclr
);
  logic wr_out, wr_set, wr_clr;
  logic [N-1:0] rd_mux;

  assign wr_out = we && (addr == A_OUT);
  assign wr_set = we && (addr == A_SET);
  assign wr_clr = we && (addr == A_CLR);
  assign iclr   = (we && (addr == A_ICLR)) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      lsel_q <= '0;
      lpol_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
    end else begin
      if (wr_out)      out_q <= wdata;
      else if (wr_set) out_q <= out_q | wdata;
      else if (wr_clr) out_q <= out_q & ~wdata;
      if (we) begin
        case (addr)
          A_DIR:  dir_q  <= wdata;
          A_LSEL: lsel_q <= wdata;
          A_LPOL: lpol_q <= wdata;
          A_RISE: rise_q <= wdata;
          A_FALL: fall_q <= wdata;
          A_MASK: mask_q <= wdata;
          A_EN:   en_q   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_DIN:   rd_mux = din;
      A_OUT:   rd_mux = out_q;
      A_DIR:   rd_mux = dir_q;
      A_LSEL:  rd_mux = lsel_q;
      A_LPOL:  rd_mux = lpol_q;
      A_RISE:  rd_mux = rise_q;
      A_FALL:  rd_mux = fall_q;
      A_MASK:  rd_mux = mask_q;
      A_EN:    rd_mux = en_q;
      A_PEND:  rd_mux = status;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R3
  out_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((out_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  logic [N_PINS-1:0] cur, prev, status, iclr;
  logic [N_PINS-1:0] dir_q, out_q, lsel_q, lpol_q, rise_q, fall_q, mask_q, en_q;
  logic irq_q;

  gpio_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .cur(cur), .prev(prev)
  );

  gpio_regfile #(.N(N_PINS)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .din(cur), .status(status),
    .dir_q(dir_q), .out_q(out_q), .lsel_q(lsel_q), .lpol_q(lpol_q),
    .rise_q(rise_q), .fall_q(fall_q), .mask_q(mask_q), .en_q(en_q), .iclr(iclr)
  );

  gpio_irq_detect #(.N(N_PINS)) u_det (
    .clk(clk), .rst(rst), .cur(cur), .prev(prev),
    .lvl_sel(lsel_q), .lvl_pol(lpol_q), .rise_en(rise_q), .fall_en(fall_q),
    .mask(mask_q), .en(en_q), .clr(iclr), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |status;
  end

  assign irq     = irq_q;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|en_q));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(|status) |-> !irq);
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  logic [15:0] v;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_we = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(4'h4, v); check("R1 dir", v, 16'h0000);
    rd(4'h1, v); check("R1 out", v, 16'h0000);
    rd(4'h9, v); check("R1 mask", v, 16'hFFFF);
    rd(4'hA, v); check("R1 en", v, 16'h0000);
    rd(4'hB, v); check("R1 pend", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 oe", pin_oe, 16'h0);
  endtask

  task automatic t_dir();
    wr(4'h4, 16'h00F0);
    check("R2 oe", pin_oe, 16'h00F0);
    rd(4'h4, v); check("R2 dir read", v, 16'h00F0);
  endtask

  task automatic t_setclr();
    wr(4'h1, 16'h1234); check("R3 out load", pin_out, 16'h1234);
    wr(4'h2, 16'h0F00); check("R3 set", pin_out, 16'h1F34);
    wr(4'h3, 16'h0034); check("R3 clear", pin_out, 16'h1F00);
    rd(4'h1, v); check("R3 readback", v, 16'h1F00);
  endtask

  task automatic t_wo();
    rd(4'h2, v); check("R10 set reads 0", v, 16'h0);
    rd(4'h3, v); check("R10 clr reads 0", v, 16'h0);
    rd(4'hC, v); check("R10 iclr reads 0", v, 16'h0);
  endtask

  task automatic t_din();
    @(negedge clk); pin_in = 16'hA5C3;
    @(negedge clk); @(negedge clk);
    rd(4'h0, v); check("R4 din", v, 16'hA5C3);
    @(negedge clk); pin_in = 16'h0000;
    settle();
  endtask

  task automatic t_edges();
    wr(4'h7, 16'h0003); wr(4'h8, 16'h0006);
    wr(4'h9, 16'hFFF0); wr(4'hA, 16'h0007);
    @(negedge clk); pin_in = 16'h0007; settle();
    rd(4'hB, v); check("R6 rise pins0-1", v, 16'h0003);
    check("R9 irq high", {15'd0, irq}, 16'h1);
    wr(4'hC, 16'h0001);
    rd(4'hB, v); check("R8 partial clear", v, 16'h0002);
    wr(4'hC, 16'h0002);
    rd(4'hB, v); check("R8 full clear", v, 16'h0000);
    check("R9 irq low", {15'd0, irq}, 16'h0);
    @(negedge clk); pin_in = 16'h0000; settle();
    rd(4'hB, v); check("R6 fall pins1-2", v, 16'h0006);
    wr(4'hC, 16'hFFFF);
  endtask

  task automatic t_gate();
    wr(4'h7, 16'h0008); wr(4'h8, 16'h0000);
    wr(4'h9, 16'hFFFF); wr(4'hA, 16'h0008);
    @(negedge clk); pin_in = 16'h0008; settle();
    rd(4'hB, v); check("R7 masked", v, 16'h0000);
    check("R7 irq masked", {15'd0, irq}, 16'h0);
    @(negedge clk); pin_in = 16'h0000; settle();
    wr(4'h9, 16'h0000); wr(4'hA, 16'h0000);
    @(negedge clk); pin_in = 16'h0008; settle();
    rd(4'hB, v); check("R7 disabled", v, 16'h0000);
    check("R7 irq disabled", {15'd0, irq}, 16'h0);
    @(negedge clk); pin_in = 16'h0000; settle();
    wr(4'h7, 16'h0000);
  endtask

  task automatic t_level();
    wr(4'h5, 16'h0030); wr(4'h6, 16'h0010);
    wr(4'h9, 16'hFFEF); wr(4'hA, 16'h0010);
    settle();
    rd(4'hB, v); check("R5 level idle", v, 16'h0000);
    @(negedge clk); pin_in = 16'h0010; settle();
    rd(4'hB, v); check("R5 level high", v, 16'h0010);
    wr(4'hC, 16'h0010);
    rd(4'hB, v); check("R5 clear ignored", v, 16'h0010);
    check("R9 level irq", {15'd0, irq}, 16'h1);
    @(negedge clk); pin_in = 16'h0000; settle();
    rd(4'hB, v); check("R5 level drop", v, 16'h0000);
    wr(4'h9, 16'hFFDF); wr(4'hA, 16'h0020);
    settle();
    rd(4'hB, v); check("R5 active low", v, 16'h0020);
    wr(4'hA, 16'h0000); settle();
    rd(4'hB, v); check("R7 enable off", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_dir(); t_setclr(); t_wo(); t_din();
    t_edges(); t_gate(); t_level();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule